// File: doc/BRIEF.md
# Indexed Remap Assignment Unit

This block applies the register-level effect of an indexed-remap setup command. It keeps four 32-bit shape registers and the remap part of the vector state word. That remap part holds five 2-bit selectors, one per operand slot: three input slots and two output slots. It also holds a 5-bit enable mask and a persistence bit. A single-cycle command strobe delivers a slot mask, a mode bit, a first-dimension size, an index register base, an element width, a swap bit (`yx`), a skip bit and the maximum vector length.

In allocation mode (mode 0), the unit clears every shape register and selector. It then walks the set mask bits from slot 0 upward and gives each one the next shape register, wrapping after shape 3. In direct mode (mode 1), the mask carries an explicit slot number and an explicit shape register number, and only those are written.

When the swap bit is set and the skip bit is clear, the second dimension is computed as the ceiling of the maximum vector length divided by the first-dimension size. An iterative divider does this, so a command takes several cycles. A one-cycle `done_o` pulse marks the point where the new state is visible.

Top module: `remap_assign_unit`

## Requirements
- R1: After reset all four shape words and the whole 64-bit state word are zero and `done_o` is low.
- R2: In `remap_state_o`, the selector of slot k (k = 0..4) sits at bits 32+2k+1 : 32+2k. The enable mask sits at bits 46:42, with slot k at bit 42+k. The persistence bit is bit 62. All other bits are zero.
- R3: In mode 0 the unit first clears all shapes and selectors. Each set mask bit k, taken in ascending order, then receives shape index (number of set mask bits below k) mod 4. That index is written to selector k and enable bit k is set. Shape register n is loaded for every n below the count of set bits. With mask 5'b11111, slots 0 and 4 both select shape 0.
- R4: Mode 0 clears the persistence bit. With an all-zero mask it leaves all shapes, selectors and enables at zero, and `done_o` still pulses.
- R5: In mode 1, mask bits 4:2 give the slot number and bits 1:0 give the shape number. Only that shape register, that slot's selector and that slot's enable bit change, and the persistence bit is set. Slot codes 5 to 7 update the shape register and the persistence bit only.
- R6: The shape word is laid out as follows. Bits 31:30 hold 0 and bits 29:28 hold the element width. Bits 27:24 hold 0 and bit 23 holds the skip bit. Bits 22:21 hold 0. Bits 20:18 hold the permute code: 110, or 111 when `yx` is 1. Bits 17:12 hold the low 6 bits of base<<2. Bits 5:0 hold the size code zero-extended, where code c means size c+1.
- R7: Bits 11:6 of the shape word hold q-1 mod 64 when `yx`=1, `skip`=0 and q = ceil(maxvl/(code+1)) is nonzero. In every other case they hold 0.
- R8: `done_o` is high for exactly one cycle per accepted command, and the new state is visible in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe, taken when idle |
| cmd_mode_i | input | 1 | 0 = allocation walk, 1 = direct slot/shape |
| cmd_mask_i | input | 5 | Slot mask, or slot/shape code in mode 1 |
| cmd_dim_i | input | 5 | First-dimension size, off by one |
| cmd_base_i | input | 5 | Index register base |
| cmd_elw_i | input | 2 | Index element width code |
| cmd_yx_i | input | 1 | Swapped dimension order |
| cmd_skip_i | input | 1 | Skip-dimension bit |
| cmd_maxvl_i | input | 7 | Maximum vector length |
| done_o | output | 1 | One-cycle completion pulse |
| shapes_o | output | 128 | Shape word n at bits 32n+31:32n |
| remap_state_o | output | 64 | Remap area of the state word |

## Verification
The bench targets the allocation wrap with all five mask bits set. A design that saturates instead of wrapping would point slot 4 at shape 3. It drives an all-zero mask after a populated state; a design that skips the clear would leave stale shapes or a stale persistence bit. Direct-mode commands with out-of-range slot codes check that no selector changes. The divider is exercised at exact multiples, non-multiples, zero length and a quotient of 64, so an off-by-one in the ceiling or the stored encoding appears directly in bits 11:6.

// File: rtl/remap_cfg_pkg.sv
package remap_cfg_pkg;
  localparam int SHAPE_W  = 32;
  localparam int NSHAPE   = 4;
  localparam int NSLOT    = 5;
  localparam int SEL_W    = 2;
  localparam int BASE_W   = 5;
  localparam int ELW_W    = 2;
  localparam int DFIELD_W = 6;
  localparam int STATE_W  = 64;
  localparam int SEL_LSB  = 32;
  localparam int EN_LSB   = 42;
  localparam int PST_BIT  = 62;
  localparam logic [2:0] PERM_XY = 3'b110;
  localparam logic [2:0] PERM_YX = 3'b111;

  typedef enum logic [1:0] {ST_IDLE, ST_DIV, ST_APPLY} cfg_state_e;

  function automatic logic [SHAPE_W-1:0] build_shape(
    input logic [ELW_W-1:0]    elw,
    input logic                skip,
    input logic                yx,
    input logic [BASE_W-1:0]   base,
    input logic [DFIELD_W-1:0] ydim,
    input logic [DFIELD_W-1:0] xdim
  );
    logic [SHAPE_W-1:0] w;
    logic [BASE_W+1:0]  sh;
    sh = {base, 2'b00};
    w = '0;
    w[29:28] = elw;
    w[23]    = skip;
    w[20:18] = yx ? PERM_YX : PERM_XY;
    w[17:12] = sh[DFIELD_W-1:0];
    w[11:6]  = ydim;
    w[5:0]   = xdim;
    return w;
  endfunction
endpackage

// File: rtl/remap_ceil_div.sv
module remap_ceil_div #(
  parameter int NUM_W = 8,
  parameter int DEN_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);
  localparam int CNT_W = $clog2(NUM_W + 1);
  localparam int PW    = NUM_W + DEN_W + 1;

  logic [NUM_W-1:0] dvd_q, num_q, quo_q;
  logic [DEN_W-1:0] den_q;
  logic [DEN_W:0]   rem_q, trial;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q, ge;

  assign trial = {rem_q[DEN_W-1:0], dvd_q[NUM_W-1]};
  assign ge    = trial >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvd_q  <= '0;
      num_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (start_i) begin
      dvd_q  <= num_i;
      num_q  <= num_i;
      den_q  <= den_i;
      rem_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= CNT_W'(NUM_W);
      done_q <= 1'b0;
    end else if (cnt_q != '0) begin
      dvd_q  <= dvd_q << 1;
      rem_q  <= ge ? (trial - {1'b0, den_q}) : trial;
      quo_q  <= {quo_q[NUM_W-2:0], ge};
      cnt_q  <= cnt_q - 1'b1;
      done_q <= (cnt_q == CNT_W'(1));
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;

  // floor(num/den) bounds; top feeds num = maxvl + den - 1 for a ceiling
  assert_quo_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (PW'(quo_q) * PW'(den_q)) <= PW'(num_q));
  assert_quo_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && den_q != '0) |-> (PW'(quo_q) + PW'(1)) * PW'(den_q) > PW'(num_q));
endmodule

// File: rtl/remap_slot_alloc.sv
module remap_slot_alloc #(
  parameter int NSLOT = 5,
  parameter int SEL_W = 2,
  localparam int CNT_W = $clog2(NSLOT + 1)
) (
  input  logic [NSLOT-1:0]             mask_i,
  output logic [NSLOT-1:0][SEL_W-1:0]  idx_o,
  output logic [CNT_W-1:0]             cnt_o
);
  always_comb begin
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < NSLOT; k++) begin
      idx_o[k] = acc[SEL_W-1:0];  // wraps modulo shape count
      acc = acc + CNT_W'(mask_i[k]);
    end
    cnt_o = acc;
  end
endmodule

// File: rtl/remap_assign_unit.sv
module remap_assign_unit
  import remap_cfg_pkg::*;
#(
  parameter int MAXVL_W = 7,
  parameter int DIM_W   = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cmd_valid_i,
  input  logic                      cmd_mode_i,
  input  logic [NSLOT-1:0]          cmd_mask_i,
  input  logic [DIM_W-1:0]          cmd_dim_i,
  input  logic [BASE_W-1:0]         cmd_base_i,
  input  logic [ELW_W-1:0]          cmd_elw_i,
  input  logic                      cmd_yx_i,
  input  logic                      cmd_skip_i,
  input  logic [MAXVL_W-1:0]        cmd_maxvl_i,
  output logic                      done_o,
  output logic [NSHAPE*SHAPE_W-1:0] shapes_o,
  output logic [STATE_W-1:0]        remap_state_o
);
  localparam int NUM_W  = MAXVL_W + 1;
  localparam int DEN_W  = DIM_W + 1;
  localparam int CNT_W  = $clog2(NSLOT + 1);
  localparam int SLOT_W = NSLOT - SEL_W;

  cfg_state_e               state_q;
  logic                     mode_q, yx_q, skip_q, done_q, persist_q;
  logic [NSLOT-1:0]         mask_q, en_q;
  logic [DIM_W-1:0]         dim_q;
  logic [BASE_W-1:0]        base_q;
  logic [ELW_W-1:0]         elw_q;
  logic [SHAPE_W-1:0]       shape_q [NSHAPE];
  logic [SEL_W-1:0]         sel_q   [NSLOT];
  logic                     div_start, div_done, apply;
  logic [NUM_W-1:0]         quo, quo_m1;
  logic [DFIELD_W-1:0]      ydim_enc;
  logic [SHAPE_W-1:0]       word;
  logic [NSLOT-1:0][SEL_W-1:0] alloc_idx;
  logic [CNT_W-1:0]         alloc_cnt;
  logic [SLOT_W-1:0]        slot_code;
  logic [SEL_W-1:0]         shp_code;

  assign div_start = (state_q == ST_IDLE) && cmd_valid_i;
  assign apply     = (state_q == ST_APPLY);
  assign slot_code = mask_q[NSLOT-1:SEL_W];
  assign shp_code  = mask_q[SEL_W-1:0];

  remap_ceil_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (div_start),
    .num_i   (NUM_W'(cmd_maxvl_i) + NUM_W'(cmd_dim_i)),
    .den_i   (DEN_W'(cmd_dim_i) + DEN_W'(1)),
    .done_o  (div_done),
    .quo_o   (quo)
  );

  remap_slot_alloc #(.NSLOT(NSLOT), .SEL_W(SEL_W)) u_alloc (
    .mask_i (mask_q),
    .idx_o  (alloc_idx),
    .cnt_o  (alloc_cnt)
  );

  assign quo_m1 = quo - NUM_W'(1);
  always_comb begin
    ydim_enc = '0;
    if (yx_q && !skip_q && quo != '0) ydim_enc = quo_m1[DFIELD_W-1:0];
  end

  assign word = build_shape(elw_q, skip_q, yx_q, base_q, ydim_enc, DFIELD_W'(dim_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      mode_q  <= 1'b0;
      mask_q  <= '0;
      dim_q   <= '0;
      base_q  <= '0;
      elw_q   <= '0;
      yx_q    <= 1'b0;
      skip_q  <= 1'b0;
    end else begin
      done_q <= apply;
      unique case (state_q)
        ST_IDLE: if (cmd_valid_i) begin
          state_q <= ST_DIV;
          mode_q  <= cmd_mode_i;
          mask_q  <= cmd_mask_i;
          dim_q   <= cmd_dim_i;
          base_q  <= cmd_base_i;
          elw_q   <= cmd_elw_i;
          yx_q    <= cmd_yx_i;
          skip_q  <= cmd_skip_i;
        end
        ST_DIV:   if (div_done) state_q <= ST_APPLY;
        ST_APPLY: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < NSHAPE; j++) shape_q[j] <= '0;
    end else if (apply) begin
      for (int j = 0; j < NSHAPE; j++) begin
        if (!mode_q) shape_q[j] <= (alloc_cnt > CNT_W'(j)) ? word : '0;
        else if (shp_code == SEL_W'(j)) shape_q[j] <= word;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NSLOT; k++) sel_q[k] <= '0;
      en_q      <= '0;
      persist_q <= 1'b0;
    end else if (apply) begin
      persist_q <= mode_q;
      for (int k = 0; k < NSLOT; k++) begin
        if (!mode_q) begin
          sel_q[k] <= mask_q[k] ? alloc_idx[k] : '0;
          en_q[k]  <= mask_q[k];
        end else if (slot_code == SLOT_W'(k)) begin
          sel_q[k] <= shp_code;
          en_q[k]  <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    remap_state_o = '0;
    for (int k = 0; k < NSLOT; k++) remap_state_o[SEL_LSB + SEL_W*k +: SEL_W] = sel_q[k];
    remap_state_o[EN_LSB +: NSLOT] = en_q;
    remap_state_o[PST_BIT]         = persist_q;
  end

  for (genvar j = 0; j < NSHAPE; j++) begin : g_shape
    assign shapes_o[j*SHAPE_W +: SHAPE_W] = shape_q[j];

    assert_perm_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (shape_q[j] != '0) |-> (shape_q[j][20:19] == 2'b11));
    assert_m1_keep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (apply && mode_q && shp_code != SEL_W'(j)) |=> $stable(shape_q[j]));
  end

  assign done_o = done_q;

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_after_apply_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply |=> done_o);
  assert_m0_persist_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apply && !mode_q) |=> !persist_q);
  assert_m0_enable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apply && !mode_q) |=> (en_q == $past(mask_q)));
  assert_m1_persist_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apply && mode_q) |=> persist_q);
endmodule

// File: tb/remap_assign_unit_tb.sv
`timescale 1ns/1ps
module remap_assign_unit_tb;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cmd_valid_i = 1'b0;
  logic         cmd_mode_i = 1'b0;
  logic [4:0]   cmd_mask_i = '0;
  logic [4:0]   cmd_dim_i = '0;
  logic [4:0]   cmd_base_i = '0;
  logic [1:0]   cmd_elw_i = '0;
  logic         cmd_yx_i = 1'b0;
  logic         cmd_skip_i = 1'b0;
  logic [6:0]   cmd_maxvl_i = '0;
  logic         done_o;
  logic [127:0] shapes_o;
  logic [63:0]  remap_state_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_shape [4];
  logic [1:0]  m_sel [5];
  logic [4:0]  m_en;
  logic        m_pst;

  remap_assign_unit u_dut (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_mode_i, .cmd_mask_i, .cmd_dim_i,
    .cmd_base_i, .cmd_elw_i, .cmd_yx_i, .cmd_skip_i, .cmd_maxvl_i,
    .done_o, .shapes_o, .remap_state_o
  );

  always #2 clk_i = ~clk_i;

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int dim, input int base, input int elw,
                                           input int yx, input int skip, input int maxvl);
    int q, y, sz;
    sz = dim + 1;
    y = 0;
    if (yx == 1 && skip == 0) begin
      q = (maxvl + sz - 1) / sz;
      if (q != 0) y = (q - 1) % 64;
    end
    return 32'((elw << 28) | (skip << 23) | ((yx == 1 ? 7 : 6) << 18) |
               (((base * 4) % 64) << 12) | (y << 6) | dim);
  endfunction

  function automatic logic [63:0] exp_state();
    logic [63:0] s;
    s = '0;
    for (int k = 0; k < 5; k++) s[32 + 2*k +: 2] = m_sel[k];
    s[46:42] = m_en;
    s[62]    = m_pst;
    return s;
  endfunction

  task automatic compare_all(input string tag);
    for (int j = 0; j < 4; j++)
      chk($sformatf("%s shape%0d", tag, j), 64'(shapes_o[j*32 +: 32]), 64'(m_shape[j]));
    chk({tag, " R2 state"}, remap_state_o, exp_state());
  endtask

  task automatic run_cmd(input string tag, input int mode, input int mask, input int dim,
                         input int base, input int elw, input int yx, input int skip,
                         input int maxvl);
    logic [31:0] w;
    int n, wait_cnt;
    @(negedge clk_i);
    cmd_valid_i = 1'b1;
    cmd_mode_i  = 1'(mode);
    cmd_mask_i  = 5'(mask);
    cmd_dim_i   = 5'(dim);
    cmd_base_i  = 5'(base);
    cmd_elw_i   = 2'(elw);
    cmd_yx_i    = 1'(yx);
    cmd_skip_i  = 1'(skip);
    cmd_maxvl_i = 7'(maxvl);
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    wait_cnt = 0;
    while (!done_o && wait_cnt < 50) begin
      @(negedge clk_i);
      wait_cnt++;
    end
    chk({tag, " R8 done seen"}, 64'(done_o), 64'(1));
    w = exp_word(dim, base, elw, yx, skip, maxvl);
    if (mode == 0) begin
      n = 0;
      for (int j = 0; j < 4; j++) m_shape[j] = '0;
      for (int k = 0; k < 5; k++) begin
        m_sel[k] = 2'b00;
        m_en[k]  = 1'b0;
        if (mask[k]) begin
          m_sel[k] = 2'(n % 4);
          m_en[k]  = 1'b1;
          if (n < 4) m_shape[n] = w;
          n++;
        end
      end
      m_pst = 1'b0;
    end else begin
      m_shape[mask & 3] = w;
      if ((mask >> 2) < 5) begin
        m_sel[mask >> 2] = 2'(mask & 3);
        m_en[mask >> 2]  = 1'b1;
      end
      m_pst = 1'b1;
    end
    compare_all(tag);
    @(negedge clk_i);
    chk({tag, " R8 pulse width"}, 64'(done_o), 64'(0));
  endtask

  task automatic t_reset();
    for (int j = 0; j < 4; j++) m_shape[j] = '0;
    for (int k = 0; k < 5; k++) m_sel[k] = '0;
    m_en = '0;
    m_pst = 1'b0;
    compare_all("R1 reset");
    chk("R1 done low", 64'(done_o), 64'(0));
  endtask

  task automatic t_alloc_partial();
    // slots 0,1,3 -> shapes 0,1,2
    run_cmd("R3 partial", 0, 5'b01011, 2, 3, 1, 0, 0, 12);
    chk("R3 slot3 sel", 64'(remap_state_o[39:38]), 64'(2));
  endtask

  task automatic t_alloc_wrap();
    run_cmd("R3 wrap", 0, 5'b11111, 3, 9, 2, 1, 0, 10);
    chk("R3 slot4 sel wraps", 64'(remap_state_o[41:40]), 64'(0));
    chk("R3 slot0 sel", 64'(remap_state_o[33:32]), 64'(0));
    // ceil(10/4)=3 -> code 2
    chk("R7 ydim 10/4", 64'(shapes_o[11:6]), 64'(2));
  endtask

  task automatic t_direct();
    run_cmd("R5 direct", 1, {3'd3, 2'd2}, 1, 4, 0, 1, 1, 30);
    chk("R5 persist", 64'(remap_state_o[62]), 64'(1));
    chk("R7 skip forces ydim 0", 64'(shapes_o[64+6 +: 6]), 64'(0));
    run_cmd("R5 slot code 6", 1, {3'd6, 2'd1}, 4, 1, 3, 0, 0, 20);
    run_cmd("R5 slot code 7", 1, {3'd7, 2'd0}, 0, 31, 0, 1, 0, 5);
  endtask

  task automatic t_zero_mask();
    run_cmd("R4 zero mask", 0, 0, 2, 2, 2, 1, 0, 9);
    chk("R4 persist cleared", 64'(remap_state_o[62]), 64'(0));
    chk("R4 all shapes clear", 64'(shapes_o == '0), 64'(1));
  endtask

  task automatic t_fields();
    // base 10110 -> (base<<2)%64 = 011000
    run_cmd("R6 fields", 1, {3'd0, 2'd3}, 7, 5'b10110, 2, 0, 1, 100);
    chk("R6 base field", 64'(shapes_o[96+12 +: 6]), 64'(6'b011000));
    chk("R6 permute xy", 64'(shapes_o[96+18 +: 3]), 64'(3'b110));
    chk("R6 xdim", 64'(shapes_o[96 +: 6]), 64'(7));
    chk("R6 skip bit", 64'(shapes_o[96+23]), 64'(1));
  endtask

  task automatic t_ceil();
    run_cmd("R7 exact 12/3", 0, 5'b00001, 2, 0, 0, 1, 0, 12);
    chk("R7 ydim exact", 64'(shapes_o[11:6]), 64'(3));
    run_cmd("R7 maxvl 0", 0, 5'b00001, 4, 0, 0, 1, 0, 0);
    chk("R7 ydim zero len", 64'(shapes_o[11:6]), 64'(0));
    run_cmd("R7 q 64", 0, 5'b00001, 0, 0, 0, 1, 0, 64);
    chk("R7 ydim 63", 64'(shapes_o[11:6]), 64'(63));
    run_cmd("R7 size 32", 0, 5'b00001, 31, 0, 0, 1, 0, 127);
    chk("R7 ydim 127/32", 64'(shapes_o[11:6]), 64'(3));
    run_cmd("R7 yx clear", 0, 5'b00001, 1, 0, 0, 0, 0, 50);
    chk("R7 ydim yx0", 64'(shapes_o[11:6]), 64'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_alloc_partial();
    t_alloc_wrap();
    t_direct();
    t_zero_mask();
    t_direct();
    t_fields();
    t_ceil();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule